// File: doc/BRIEF.md
# Wavetable Channel Phase Engine

This block produces the sample stream of one voice of a table-driven tone generator. A periodic sample tick drives it. On each tick a 16-bit phase counter in 12.4 fixed point is reduced by a tuning step. The step is the number of source-synth clock cycles that pass per tick, adjustable in sixteenths. When the subtraction borrows, the channel period is added back to the counter and a pointer into a shared wave RAM moves one entry forward.

The pointer runs inside a programmable window. When an advance would carry it past the window's last index, it is reloaded with the window's first index. A square wave with a selectable duty, a stepped ramp or any other shape is therefore just a choice of window over the table contents.

On every tick the block registers the product of the channel volume and the RAM entry at the pointer that the tick produces. This product is the channel sample. The counter and the pointer are also brought out so that a neighbouring block can follow the phase. Mixing, register decoding and fraction dithering belong to other blocks.

Top module: `wt_voice`

## Requirements
- R1: A synchronous reset sets the phase counter to 0, sets the sample output to 0 and loads the pointer with the current window start input.
- R2: In a cycle without a tick (and without reset), the phase counter, the pointer and the sample output keep their values, whatever the other inputs do.
- R3: On a tick where the counter is at least the tuning step, the counter becomes counter minus step and the pointer does not move.
- R4: On a tick where the counter is below the tuning step, the counter becomes (counter − step + period) modulo 2^16 and the pointer advances by one.
- R5: When an advance would take the pointer above the window last index (also when start > last), the pointer is loaded with the window start index instead.
- R6: On each tick the sample output becomes volume × RAM[pointer after that tick], registered at the tick's clock edge. A volume change made without a tick leaves the output unchanged until the next tick.
- R7: A wave RAM write is committed at the clock edge. A tick in the same cycle that reads the address being written uses the old entry, and the next tick uses the new one.
- R8: RAM addresses at or above the table depth (64 by default) hold no storage. Writes to them are ignored and a pointer there reads as entry value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample tick, one cycle wide |
| tune_step | input | 16 | Tuning step subtracted per tick, 12.4 fixed point |
| period | input | 16 | Channel period added on borrow, 12.4 fixed point |
| win_start | input | 8 | First pointer index of the window |
| win_last | input | 8 | Last pointer index of the window |
| volume | input | 4 | Channel volume |
| wr_en | input | 1 | Wave RAM write strobe |
| wr_addr | input | 8 | Wave RAM write address |
| wr_data | input | 8 | Wave RAM write data |
| sample_out | output | 12 | Registered channel sample |
| phase_cnt | output | 16 | Current phase counter |
| wave_ptr | output | 8 | Current wave RAM pointer |

## Verification
Each result is due in the clock edge that samples the tick (or the reset, or the write). The counter, the pointer and the product are all one register deep, and the RAM read is combinational on the next pointer. The bench therefore drives every input just after a falling edge and compares against its arithmetic model at the following falling edge, one rising edge later. Runs of idle cycles with changing inputs are followed by a comparison at their end, to show that nothing moved. The same-cycle write test places the write and the tick on one falling-to-falling interval and expects the old entry first and the new entry one tick later.

// File: rtl/wt_pkg.sv
package wt_pkg;
   // How the volume scaling is built.
   typedef enum logic [0:0] {
      MUL_OPERATOR = 1'b0,  // single multiply operator
      MUL_SHIFTADD = 1'b1   // explicit partial products, one per volume bit
   } mul_style_e;

   localparam int unsigned CNT_W_DEF  = 16;
   localparam int unsigned FRAC_W_DEF = 4;
   localparam int unsigned PTR_W_DEF  = 8;
   localparam int unsigned DEPTH_DEF  = 64;
   localparam int unsigned VOL_W_DEF  = 4;
   localparam int unsigned SMP_W_DEF  = 8;
endpackage

// File: rtl/wt_phase_acc.sv
module wt_phase_acc #(
   parameter int unsigned CNT_W  = wt_pkg::CNT_W_DEF,
   parameter int unsigned FRAC_W = wt_pkg::FRAC_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [CNT_W-1:0] step,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt_q,
   output logic             adv
);
   localparam int unsigned INT_W = CNT_W - FRAC_W;

   if (FRAC_W >= CNT_W) begin : g_bad_frac
      $error("wt_phase_acc: FRAC_W must be below CNT_W");
   end
   if (INT_W < 1) begin : g_bad_int
      $error("wt_phase_acc: no integer bits left");
   end

   logic [CNT_W:0]   diff;
   logic             borrow;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      diff   = {1'b0, cnt_q} - {1'b0, step};
      borrow = diff[CNT_W];
      reload = diff[CNT_W-1:0] + period;
      adv    = tick & borrow;
      cnt_d  = cnt_q;
      if (tick) begin
         cnt_d = borrow ? reload : diff[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   AST_CNT_RESET: assert property (@(posedge clk) rst |=> cnt_q == '0);  // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q));  // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q >= step) |=> cnt_q == CNT_W'($past(cnt_q) - $past(step)));  // R3
   AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q < step) |=>
         cnt_q == CNT_W'($past(cnt_q) - $past(step) + $past(period)));  // R4
   AST_ADV_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      adv |-> tick);  // R2
endmodule

// File: rtl/wt_ptr_win.sv
module wt_ptr_win #(
   parameter int unsigned PTR_W = wt_pkg::PTR_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic [PTR_W-1:0] start,
   input  logic [PTR_W-1:0] last,
   output logic [PTR_W-1:0] ptr_q,
   output logic [PTR_W-1:0] ptr_nxt
);
   if (PTR_W < 1 || PTR_W > 16) begin : g_bad_ptr
      $error("wt_ptr_win: PTR_W out of range");
   end

   logic [PTR_W:0]   inc;
   logic             past_end;
   logic [PTR_W-1:0] stepped;

   always_comb begin
      inc      = {1'b0, ptr_q} + 1'b1;
      past_end = inc > {1'b0, last};
      stepped  = past_end ? start : inc[PTR_W-1:0];
      if (rst)      ptr_nxt = start;
      else if (adv) ptr_nxt = stepped;
      else          ptr_nxt = ptr_q;
   end

   always_ff @(posedge clk) begin
      ptr_q <= ptr_nxt;
   end

   AST_PTR_RESET: assert property (@(posedge clk) rst |=> ptr_q == $past(start));  // R1
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(ptr_q));  // R3
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
      (adv && ptr_q >= last) |=> ptr_q == $past(start));  // R5
   AST_PTR_ADV: assert property (@(posedge clk) disable iff (rst)
      (adv && ptr_q < last) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));  // R4
endmodule

// File: rtl/wt_wave_ram.sv
module wt_wave_ram #(
   parameter int unsigned PTR_W = wt_pkg::PTR_W_DEF,
   parameter int unsigned DEPTH = wt_pkg::DEPTH_DEF,
   parameter int unsigned SMP_W = wt_pkg::SMP_W_DEF
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [SMP_W-1:0] wr_data,
   input  logic [PTR_W-1:0] rd_addr,
   output logic [SMP_W-1:0] rd_data
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W:0] DEPTH_V = (PTR_W+1)'(DEPTH);

   if (DEPTH < 2 || DEPTH > (1 << PTR_W)) begin : g_bad_depth
      $error("wt_wave_ram: DEPTH must be 2..2**PTR_W");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_pow2
      $error("wt_wave_ram: DEPTH must be a power of two");
   end

   logic [SMP_W-1:0] mem [DEPTH];
   logic             wr_hit;
   logic             rd_hit;

   assign wr_hit = wr_en && ({1'b0, wr_addr} < DEPTH_V);
   assign rd_hit = {1'b0, rd_addr} < DEPTH_V;

   // One write port per entry, decoded from the low address bits.
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_hit && wr_addr[AW-1:0] == AW'(e)) mem[e] <= wr_data;
      end
   end

   assign rd_data = rd_hit ? mem[rd_addr[AW-1:0]] : '0;

   AST_RD_OOR_ZERO: assert property (@(posedge clk)
      !rd_hit |-> rd_data == '0);  // R8
endmodule

// File: rtl/wt_scale.sv
module wt_scale #(
   parameter int unsigned          VOL_W = wt_pkg::VOL_W_DEF,
   parameter int unsigned          SMP_W = wt_pkg::SMP_W_DEF,
   parameter wt_pkg::mul_style_e   STYLE = wt_pkg::MUL_OPERATOR,
   localparam int unsigned         OUT_W = VOL_W + SMP_W
) (
   input  logic [VOL_W-1:0] vol,
   input  logic [SMP_W-1:0] smp,
   output logic [OUT_W-1:0] prod
);
   if (VOL_W < 1 || SMP_W < 1) begin : g_bad_w
      $error("wt_scale: widths must be positive");
   end

   if (STYLE == wt_pkg::MUL_OPERATOR) begin : g_op
      assign prod = OUT_W'(vol) * OUT_W'(smp);
   end else begin : g_sa
      logic [OUT_W-1:0] part [VOL_W];
      for (genvar b = 0; b < VOL_W; b++) begin : g_part
         assign part[b] = vol[b] ? (OUT_W'(smp) << b) : '0;
      end
      always_comb begin
         prod = '0;
         for (int b = 0; b < VOL_W; b++) prod = prod + part[b];
      end
   end
endmodule

// File: rtl/wt_voice.sv
module wt_voice #(
   parameter int unsigned        CNT_W     = wt_pkg::CNT_W_DEF,
   parameter int unsigned        FRAC_W    = wt_pkg::FRAC_W_DEF,
   parameter int unsigned        PTR_W     = wt_pkg::PTR_W_DEF,
   parameter int unsigned        DEPTH     = wt_pkg::DEPTH_DEF,
   parameter int unsigned        VOL_W     = wt_pkg::VOL_W_DEF,
   parameter int unsigned        SMP_W     = wt_pkg::SMP_W_DEF,
   parameter wt_pkg::mul_style_e MUL_STYLE = wt_pkg::MUL_OPERATOR,
   localparam int unsigned       OUT_W     = VOL_W + SMP_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [CNT_W-1:0] tune_step,
   input  logic [CNT_W-1:0] period,
   input  logic [PTR_W-1:0] win_start,
   input  logic [PTR_W-1:0] win_last,
   input  logic [VOL_W-1:0] volume,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [SMP_W-1:0] wr_data,
   output logic [OUT_W-1:0] sample_out,
   output logic [CNT_W-1:0] phase_cnt,
   output logic [PTR_W-1:0] wave_ptr
);
   logic             adv;
   logic [PTR_W-1:0] ptr_nxt;
   logic [SMP_W-1:0] entry;
   logic [OUT_W-1:0] prod;

   wt_phase_acc #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .tick(tick), .step(tune_step), .period(period),
      .cnt_q(phase_cnt), .adv(adv)
   );

   wt_ptr_win #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst(rst), .adv(adv), .start(win_start), .last(win_last),
      .ptr_q(wave_ptr), .ptr_nxt(ptr_nxt)
   );

   wt_wave_ram #(.PTR_W(PTR_W), .DEPTH(DEPTH), .SMP_W(SMP_W)) u_ram (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(ptr_nxt), .rd_data(entry)
   );

   wt_scale #(.VOL_W(VOL_W), .SMP_W(SMP_W), .STYLE(MUL_STYLE)) u_scale (
      .vol(volume), .smp(entry), .prod(prod)
   );

   always_ff @(posedge clk) begin
      if (rst)       sample_out <= '0;
      else if (tick) sample_out <= prod;
   end

   AST_OUT_RESET: assert property (@(posedge clk) rst |=> sample_out == '0);  // R1
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(sample_out));  // R2
   AST_OUT_MUTE: assert property (@(posedge clk) disable iff (rst)
      (tick && volume == '0) |=> sample_out == '0);  // R6
endmodule

// File: tb/wt_voice_tb.sv
`timescale 1ns/1ps
module wt_voice_tb;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] tune_step = '0;
   logic [15:0] period = '0;
   logic [7:0]  win_start = '0;
   logic [7:0]  win_last = '0;
   logic [3:0]  volume = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [11:0] sample_out;
   logic [15:0] phase_cnt;
   logic [7:0]  wave_ptr;

   always #2 clk = ~clk;

   wt_voice u_dut (
      .clk(clk), .rst(rst), .tick(tick), .tune_step(tune_step), .period(period),
      .win_start(win_start), .win_last(win_last), .volume(volume),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sample_out(sample_out), .phase_cnt(phase_cnt), .wave_ptr(wave_ptr)
   );

   int errs = 0;
   int checks = 0;
   int m_cnt, m_ptr, m_out;
   int mem [DEPTH];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rd(input int p);
      return (p < DEPTH) ? mem[p] : 0;
   endfunction

   task automatic cmp_state(input string tag);
      chk(int'(phase_cnt) == m_cnt, {tag, " counter"}, int'(phase_cnt), m_cnt);
      chk(int'(wave_ptr) == m_ptr, {tag, " pointer"}, int'(wave_ptr), m_ptr);
      chk(int'(sample_out) == m_out, {tag, " sample"}, int'(sample_out), m_out);
   endtask

   // All tasks start and end just after a falling edge.
   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_cnt = 0; m_ptr = int'(win_start); m_out = 0;
      cmp_state("R1 reset");
   endtask

   task automatic write_ram(input int a, input int d);
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
      if (a < DEPTH) mem[a] = d;
   endtask

   task automatic model_tick();
      int d;
      bit adv;
      d = m_cnt - int'(tune_step);
      adv = 1'b0;
      if (d < 0) begin
         m_cnt = (d + int'(period)) & 16'hFFFF;
         adv = 1'b1;
      end else begin
         m_cnt = d;
      end
      if (adv) begin
         if (m_ptr + 1 > int'(win_last)) m_ptr = int'(win_start);
         else m_ptr = m_ptr + 1;
      end
      m_out = int'(volume) * rd(m_ptr);
   endtask

   task automatic do_tick(input string tag);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      model_tick();
      cmp_state(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         volume = 4'(volume + 4'd3);
         tune_step = tune_step ^ 16'h0101;
         @(negedge clk);
      end
      chk(int'(phase_cnt) == m_cnt, "R2 idle counter", int'(phase_cnt), m_cnt);
      chk(int'(wave_ptr) == m_ptr, "R2 idle pointer", int'(wave_ptr), m_ptr);
      chk(int'(sample_out) == m_out, "R2 idle sample", int'(sample_out), m_out);
   endtask

   initial begin
      #(200000 * 4);
      errs++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
   end

   initial begin
      int ws [5], wl [5], st [4], pe [4];
      int save;
      ws = '{0, 15, 32, 60, 40};  wl = '{15, 30, 45, 63, 20};
      st = '{458, 16, 1000, 7};   pe = '{4096, 40, 300, 9};
      @(negedge clk);
      @(negedge clk);
      for (int a = 0; a < DEPTH; a++) write_ram(a, (a * 37 + 5) & 255);

      // R3 R4 R5 R6: sweep windows, tunings and every volume.
      for (int w = 0; w < 5; w++) begin
         for (int t = 0; t < 4; t++) begin
            win_start = 8'(ws[w]); win_last = 8'(wl[w]);
            tune_step = 16'(st[t]); period = 16'(pe[t]);
            do_reset();
            for (int k = 0; k < 48; k++) begin
               volume = 4'(k + w);
               do_tick("R3 R4 R5 R6 sweep");
            end
            save = int'(tune_step);
            idle(3);
            tune_step = 16'(save);
         end
      end

      // R6: volume change without tick waits for the next tick.
      win_start = 8'd4; win_last = 8'd9; tune_step = 16'd458; period = 16'd600;
      volume = 4'd5;
      do_reset();
      do_tick("R6 setup");
      volume = 4'd11;
      @(negedge clk);
      chk(int'(sample_out) == m_out, "R6 volume no tick", int'(sample_out), m_out);
      do_tick("R6 volume applied");

      // R7: write to the read address in the tick cycle gives old data.
      tune_step = 16'd0;
      m_cnt = m_cnt; // counter never borrows with a zero step from here
      wr_en = 1'b1; wr_addr = 8'(m_ptr); wr_data = 8'(rd(m_ptr) ^ 8'hA5);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      m_out = int'(volume) * rd(m_ptr);
      chk(int'(sample_out) == m_out, "R7 same-cycle old data", int'(sample_out), m_out);
      mem[m_ptr] = int'(wr_data);
      do_tick("R7 new data next tick");

      // R8: write beyond depth ignored; pointer beyond depth reads zero.
      write_ram(200, 8'h00);   // would alias entry 8 if not ignored
      win_start = 8'd8; win_last = 8'd8; tune_step = 16'd16; period = 16'd16;
      volume = 4'd15;
      do_reset();
      do_tick("R8 alias untouched");
      do_tick("R8 alias untouched");
      win_start = 8'd100; win_last = 8'd101;
      do_reset();
      do_tick("R8 pointer beyond depth");
      do_tick("R8 pointer beyond depth");

      // R5: start above last, every advance returns to start.
      win_start = 8'd50; win_last = 8'd10; tune_step = 16'd458; period = 16'd100;
      volume = 4'd7;
      do_reset();
      for (int k = 0; k < 6; k++) do_tick("R5 start above last");

      // R1: reset in mid-run.
      win_start = 8'd3;
      do_reset();

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule